// File: doc/BRIEF.md
# Descending word stack controller

This block keeps a last-in first-out stack of 16-bit words in a small internal byte memory. A 16-bit stack pointer marks the top of the stack. Each word that goes on the stack moves the pointer two bytes toward lower addresses, and each word taken off moves it two bytes back up. Four request inputs drive it: a plain push and a plain pop for data words, and a call and a return that carry an instruction pointer. A call saves the instruction pointer given with it. A return takes the saved word back off and presents it as the restored instruction pointer. A separate frame pointer can take a copy of the stack pointer, so that a caller can address parameters and locals relative to a fixed frame.

A push first lowers the pointer and then writes the word at the new pointer. The low byte goes to the lower address and the high byte to the next address. A pop reads the word at the current pointer and then raises the pointer. The usable region lies between a lower limit address and the reset address. A request that would leave that region is refused and flagged, and a cycle that carries more than one request is also refused and flagged. A refused request changes neither the pointer nor the memory.

Top module: `word_stack_ctl`

## Requirements
- R1: After reset, `sp_o` and `bp_o` both equal the parameter SP_RESET, and `pop_valid_o`, `ip_valid_o`, `ovf_o`, `unf_o` and `conflict_o` are all 0.
- R2: An accepted push or call lowers `sp_o` by exactly 2, and the new value is visible in the cycle after the request.
- R3: An accepted pop raises `sp_o` by exactly 2. In the cycle after the request it sets `pop_valid_o` to 1 for one cycle, and `pop_data_o` then holds the word at the top of the stack.
- R4: Words come off the stack in the reverse of the order they went on. After N pushes, N pops return them last-first.
- R5: A call stores `ip_i` on the stack exactly as a push of that value would, so a later pop returns it.
- R6: An accepted return raises `sp_o` by 2. In the cycle after the request it sets `ip_valid_o` to 1 for one cycle, with `ip_o` equal to the word saved by the matching call. A return leaves `pop_valid_o` at 0.
- R7: When `frame_load_i` is 1, `bp_o` takes in the next cycle the value `sp_o` had in the request cycle. Otherwise `bp_o` holds its value.
- R8: A push or call is refused when `sp_o` minus 2 would fall below SP_LIMIT. In that case `ovf_o` is 1 in the next cycle, `sp_o` is unchanged, and the stored words are unchanged.
- R9: A pop or return is refused when `sp_o` plus 2 would exceed SP_RESET. In that case `unf_o` is 1 in the next cycle, `sp_o` is unchanged, and neither valid output rises.
- R10: When two or more of `push_i`, `pop_i`, `call_i` and `ret_i` are 1 in the same cycle, nothing is performed. `conflict_o` is 1 in the next cycle, `sp_o` is unchanged, and no valid output rises. At most one of the three flags is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push `push_data_i` |
| pop_i | input | 1 | Pop the top word to `pop_data_o` |
| call_i | input | 1 | Save `ip_i` on the stack |
| ret_i | input | 1 | Restore the top word to `ip_o` |
| frame_load_i | input | 1 | Copy the stack pointer into the frame pointer |
| push_data_i | input | 16 | Word to push |
| ip_i | input | 16 | Instruction pointer to save on a call |
| sp_o | output | 16 | Current stack pointer |
| bp_o | output | 16 | Frame pointer |
| pop_data_o | output | 16 | Last popped word |
| pop_valid_o | output | 1 | One-cycle strobe for `pop_data_o` |
| ip_o | output | 16 | Restored instruction pointer |
| ip_valid_o | output | 1 | One-cycle strobe for `ip_o` |
| ovf_o | output | 1 | Push or call refused at the limit |
| unf_o | output | 1 | Pop or return refused on an empty stack |
| conflict_o | output | 1 | Several requests in one cycle, all refused |

## Verification
The bench builds the block with SP_RESET = 1000, SP_LIMIT = 988 and a 16-byte memory. With this reset value, pushes step the pointer through 998 and 996 and pops step it back to 1000. The limit leaves room for exactly six words, so the seventh push hits the overflow path after only a few cycles. A 1000-based pointer also makes the memory index wrap inside the 16-byte array. Together these values show that addresses taken from the low pointer bits keep all six stored words apart.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2
  } stk_op_e;

  // Pointer after one word goes on the stack.
  function automatic logic [15:0] sp_after_push(input logic [15:0] sp);
    return sp - 16'd2;
  endfunction

  // Pointer after one word comes off the stack.
  function automatic logic [15:0] sp_after_pop(input logic [15:0] sp);
    return sp + 16'd2;
  endfunction

  // A push fits if sp-2 stays at or above the lower limit (17-bit compare, no wrap).
  function automatic logic push_fits(input logic [15:0] sp, input logic [15:0] lim);
    return ({1'b0, sp} >= ({1'b0, lim} + 17'd2));
  endfunction

  // A pop is legal if sp+2 stays at or below the stack base (the reset value).
  function automatic logic pop_has_word(input logic [15:0] sp, input logic [15:0] base);
    return (({1'b0, sp} + 17'd2) <= {1'b0, base});
  endfunction

endpackage

// File: rtl/stk_arbiter.sv
module stk_arbiter
  import stk_pkg::*;
#(
  parameter logic [15:0] SP_LIMIT = 16'd0,
  parameter logic [15:0] SP_BASE  = 16'd64
) (
  input  logic        push_i,
  input  logic        pop_i,
  input  logic        call_i,
  input  logic        ret_i,
  input  logic [15:0] sp_i,
  output stk_op_e     op_o,
  output logic        sel_ip_o,
  output logic        is_ret_o,
  output logic        ev_conflict_o,
  output logic        ev_ovf_o,
  output logic        ev_unf_o
);

  logic [3:0] req;
  logic       want_wr;
  logic       want_rd;
  logic       fits;
  logic       has;

  assign req     = {ret_i, call_i, pop_i, push_i};
  assign want_wr = push_i | call_i;
  assign want_rd = pop_i | ret_i;
  assign fits    = push_fits(sp_i, SP_LIMIT);
  assign has     = pop_has_word(sp_i, SP_BASE);

  always_comb begin
    ev_conflict_o = ((req & (req - 4'd1)) != 4'd0);
    ev_ovf_o      = !ev_conflict_o && want_wr && !fits;
    ev_unf_o      = !ev_conflict_o && want_rd && !has;
    op_o          = OP_IDLE;
    if (!ev_conflict_o) begin
      if (want_wr && fits)     op_o = OP_WR;
      else if (want_rd && has) op_o = OP_RD;
    end
  end

  assign sel_ip_o = call_i;
  assign is_ret_o = ret_i;

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter logic [15:0] SP_RESET = 16'd64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  stk_op_e     op_i,
  input  logic        frame_load_i,
  output logic [15:0] sp_o,
  output logic [15:0] bp_o
);

  logic [15:0] sp_q;
  logic [15:0] bp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= SP_RESET;
      bp_q <= SP_RESET;
    end else begin
      case (op_i)
        OP_WR:   sp_q <= sp_after_push(sp_q);
        OP_RD:   sp_q <= sp_after_pop(sp_q);
        default: sp_q <= sp_q;
      endcase
      if (frame_load_i) bp_q <= sp_q;
    end
  end

  assign sp_o = sp_q;
  assign bp_o = bp_q;

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_WR) |=> (sp_q == $past(sp_q) - 16'd2));

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RD) |=> (sp_q == $past(sp_q) + 16'd2));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_IDLE) |=> $stable(sp_q));

  // R7
  frame_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load_i |=> (bp_q == $past(sp_q)));

endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int BYTES = 64
) (
  input  logic                     clk,
  input  logic                     we_i,
  input  logic [$clog2(BYTES)-1:0] waddr_i,
  input  logic [15:0]              wdata_i,
  input  logic [$clog2(BYTES)-1:0] raddr_i,
  output logic [15:0]              rdata_o
);

  localparam int AW = $clog2(BYTES);

  logic [7:0]    mem [BYTES];
  logic [AW-1:0] whi;
  logic [AW-1:0] rhi;

  assign whi = waddr_i + AW'(1);
  assign rhi = raddr_i + AW'(1);

  // Little-endian: the low byte goes at the word address, the high byte one above it.
  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i[7:0];
      mem[whi]     <= wdata_i[15:8];
    end
  end

  assign rdata_o = {mem[rhi], mem[raddr_i]};

endmodule

// File: rtl/word_stack_ctl.sv
module word_stack_ctl
  import stk_pkg::*;
#(
  parameter int          MEM_BYTES = 64,
  parameter logic [15:0] SP_RESET  = 16'd64,
  parameter logic [15:0] SP_LIMIT  = 16'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_i,
  input  logic        pop_i,
  input  logic        call_i,
  input  logic        ret_i,
  input  logic        frame_load_i,
  input  logic [15:0] push_data_i,
  input  logic [15:0] ip_i,
  output logic [15:0] sp_o,
  output logic [15:0] bp_o,
  output logic [15:0] pop_data_o,
  output logic        pop_valid_o,
  output logic [15:0] ip_o,
  output logic        ip_valid_o,
  output logic        ovf_o,
  output logic        unf_o,
  output logic        conflict_o
);

  localparam int MAW = $clog2(MEM_BYTES);

  stk_op_e     op;
  logic        sel_ip;
  logic        is_ret;
  logic        ev_conflict;
  logic        ev_ovf;
  logic        ev_unf;
  logic [15:0] sp_cur;
  logic [15:0] wr_word;
  logic [15:0] rd_word;

  stk_arbiter #(.SP_LIMIT(SP_LIMIT), .SP_BASE(SP_RESET)) u_arb (
    .push_i        (push_i),
    .pop_i         (pop_i),
    .call_i        (call_i),
    .ret_i         (ret_i),
    .sp_i          (sp_cur),
    .op_o          (op),
    .sel_ip_o      (sel_ip),
    .is_ret_o      (is_ret),
    .ev_conflict_o (ev_conflict),
    .ev_ovf_o      (ev_ovf),
    .ev_unf_o      (ev_unf)
  );

  stk_ptr #(.SP_RESET(SP_RESET)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op),
    .frame_load_i (frame_load_i),
    .sp_o         (sp_cur),
    .bp_o         (bp_o)
  );

  assign wr_word = sel_ip ? ip_i : push_data_i;

  stk_ram #(.BYTES(MEM_BYTES)) u_ram (
    .clk     (clk),
    .we_i    (op == OP_WR),
    .waddr_i (MAW'(sp_after_push(sp_cur))),
    .wdata_i (wr_word),
    .raddr_i (MAW'(sp_cur)),
    .rdata_o (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_data_o  <= '0;
      pop_valid_o <= 1'b0;
      ip_o        <= '0;
      ip_valid_o  <= 1'b0;
      ovf_o       <= 1'b0;
      unf_o       <= 1'b0;
      conflict_o  <= 1'b0;
    end else begin
      pop_valid_o <= (op == OP_RD) && !is_ret;
      ip_valid_o  <= (op == OP_RD) && is_ret;
      if (op == OP_RD && !is_ret) pop_data_o <= rd_word;
      if (op == OP_RD && is_ret)  ip_o       <= rd_word;
      ovf_o      <= ev_ovf;
      unf_o      <= ev_unf;
      conflict_o <= ev_conflict;
    end
  end

  assign sp_o = sp_cur;

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> (ovf_o && $stable(sp_o)));

  // R9
  unf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> (unf_o && !pop_valid_o && !ip_valid_o && $stable(sp_o)));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_o, unf_o, conflict_o}));

  // R10
  conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_conflict |=> (conflict_o && !pop_valid_o && !ip_valid_o && $stable(sp_o)));

  // R6
  ret_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD && is_ret) |=> (ip_valid_o && !pop_valid_o));

endmodule

// File: tb/word_stack_ctl_test.sv
module word_stack_ctl_test;

  localparam logic [15:0] RST_SP = 16'd1000;
  localparam logic [15:0] LIM_SP = 16'd988;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, call_i = 0, ret_i = 0, frame_load_i = 0;
  logic [15:0] push_data_i = '0, ip_i = '0;
  logic [15:0] sp_o, bp_o, pop_data_o, ip_o;
  logic        pop_valid_o, ip_valid_o, ovf_o, unf_o, conflict_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          model_sp;
  logic [15:0] model_stk[$];
  logic [15:0] exp_pop_q[$];
  logic [15:0] exp_ip_q[$];

  always #5 clk = ~clk;

  word_stack_ctl #(.MEM_BYTES(16), .SP_RESET(RST_SP), .SP_LIMIT(LIM_SP)) uut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
    .ret_i(ret_i), .frame_load_i(frame_load_i), .push_data_i(push_data_i), .ip_i(ip_i),
    .sp_o(sp_o), .bp_o(bp_o), .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
    .ip_o(ip_o), .ip_valid_o(ip_valid_o), .ovf_o(ovf_o), .unf_o(unf_o),
    .conflict_o(conflict_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compares each strobed result against the scoreboard queues.
  always @(negedge clk) begin
    if (rst_n && pop_valid_o) begin
      if (exp_pop_q.size() == 0) chk(0, "R3 unexpected pop_valid", 1, 0);
      else begin
        logic [15:0] e;
        e = exp_pop_q.pop_front();
        chk(pop_data_o == e, "R3/R4 pop data", pop_data_o, e);
      end
    end
    if (rst_n && ip_valid_o) begin
      if (exp_ip_q.size() == 0) chk(0, "R6 unexpected ip_valid", 1, 0);
      else begin
        logic [15:0] e;
        e = exp_ip_q.pop_front();
        chk(ip_o == e, "R6 restored ip", ip_o, e);
      end
    end
  end

  task automatic clear_in();
    push_i = 0; pop_i = 0; call_i = 0; ret_i = 0; frame_load_i = 0;
  endtask

  // Push (or call) with model update; checks pointer and overflow flag (R2, R5, R8).
  task automatic put(input bit as_call, input logic [15:0] d);
    bit over;
    over = (model_sp - 2) < int'(LIM_SP);
    if (as_call) begin call_i = 1; ip_i = d; end
    else begin push_i = 1; push_data_i = d; end
    @(negedge clk);
    clear_in();
    if (!over) begin
      model_sp -= 2;
      model_stk.push_back(d);
    end
    chk(sp_o == 16'(model_sp), over ? "R8 sp held on overflow" : "R2 sp after push", sp_o, model_sp);
    chk(ovf_o == over, "R8 ovf flag", ovf_o, over);
  endtask

  // Pop (or return) with model update; checks pointer and underflow flag (R3, R6, R9).
  task automatic take(input bit as_ret);
    bit empty;
    empty = (model_stk.size() == 0);
    if (!empty) begin
      if (as_ret) exp_ip_q.push_back(model_stk.pop_back());
      else        exp_pop_q.push_back(model_stk.pop_back());
    end
    if (as_ret) ret_i = 1; else pop_i = 1;
    @(negedge clk);
    clear_in();
    if (!empty) model_sp += 2;
    chk(sp_o == 16'(model_sp), empty ? "R9 sp held on underflow" : "R3 sp after pop", sp_o, model_sp);
    chk(unf_o == empty, "R9 unf flag", unf_o, empty);
    if (empty) begin
      chk(!pop_valid_o && !ip_valid_o, "R9 no valid on underflow", pop_valid_o | ip_valid_o, 0);
    end
    if (as_ret && !empty) chk(!pop_valid_o, "R6 ret leaves pop_valid low", pop_valid_o, 0);
  endtask

  task automatic clash(input logic [3:0] r);
    {ret_i, call_i, pop_i, push_i} = r;
    push_data_i = 16'hDEAD; ip_i = 16'hDEAD;
    @(negedge clk);
    clear_in();
    chk(conflict_o == 1'b1, "R10 conflict flag", conflict_o, 1);
    chk(sp_o == 16'(model_sp), "R10 sp held", sp_o, model_sp);
    chk(!pop_valid_o && !ip_valid_o, "R10 no valid", pop_valid_o | ip_valid_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_sp = int'(RST_SP);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sp_o == RST_SP, "R1 sp reset", sp_o, RST_SP);
    chk(bp_o == RST_SP, "R1 bp reset", bp_o, RST_SP);
    chk({pop_valid_o, ip_valid_o, ovf_o, unf_o, conflict_o} == 5'b0, "R1 strobes and flags low",
        {pop_valid_o, ip_valid_o, ovf_o, unf_o, conflict_o}, 0);

    // R2: 1000 -> 998 -> 996
    put(0, 16'h0009);
    put(0, 16'h000A);

    // R7 frame pointer copy
    frame_load_i = 1;
    @(negedge clk);
    clear_in();
    chk(bp_o == 16'd996, "R7 bp loaded", bp_o, 996);
    put(0, 16'h7777);
    chk(bp_o == 16'd996, "R7 bp holds", bp_o, 996);
    take(0);

    // R3/R4: pops come back last-first
    take(0);
    take(0);
    // R9 underflow on an empty stack, both paths
    take(0);
    take(1);

    // R5/R6: call saves ip, data nests above it, return restores it
    put(1, 16'h1234);
    put(0, 16'hBEEF);
    take(0);
    take(1);

    // R8: fill six words, seventh overflows, then drain in reverse (R4)
    for (int i = 0; i < 7; i++) put(0, 16'(16'hA100 + i * 16'h0111));
    chk(sp_o == LIM_SP, "R8 sp at limit", sp_o, LIM_SP);
    // R10 conflicts with a non-empty stack
    clash(4'b0011);
    clash(4'b1100);
    clash(4'b0110);
    for (int i = 0; i < 7; i++) take(0);

    // R10 conflict on an empty stack
    clash(4'b1001);

    @(negedge clk);
    chk(exp_pop_q.size() == 0 && exp_ip_q.size() == 0, "R4 scoreboard drained",
        exp_pop_q.size() + exp_ip_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule